// File: doc/BRIEF.md
# ADC Result Buffer with Block-Count DMA Request

This block buffers the output of an analog-to-digital converter that runs without pause on a single input. Each conversion result (12 bits) arrives with a one-cycle write strobe and is stored in a 64-word first-in first-out store reserved for that one conversion stream. A DMA engine drains the store one word per read strobe, so samples can reach a circular buffer in memory with no processor involvement.

The DMA request does not depend on how full the store is. Instead it counts accepted results. Each time a programmable number of results (the block size) has been completely written, the block raises a one-cycle request, so a DMA frame of that length always finds its data present. Requests that come too close together to be shown as separate pulses are queued, and none is lost. Every read returns a 32-bit word that carries the result together with status flags. A read made while the store is empty does not stall: it returns a word with its top bit set, which marks the word as not holding a result.

Top module: `adc_blkfifo`

## Requirements
- R1: After synchronous reset the outputs are as follows: `empty`=1, `full`=0, `level`=0, `ovf`=0, `dma_req`=0 and `rd_word`=0x8000_0000.
- R2: A read of a non-empty store returns the oldest result in first-in first-out order. The word is laid out as: bits 11:0 hold the result, bit 31 is 0, bits 29:12 are 0, and bit 30 is the overflow flag as it stood at the read.
- R3: A write while the store is full and no read is made in the same cycle is dropped. The store contents and `level` are left unchanged, and `ovf` goes to 1 one cycle later.
- R4: `ovf` goes to 0 on the cycle after an `ovf_clr` strobe. If a dropped write happens in the same cycle, the set wins.
- R5: A read while the store is empty returns a word with bit 31 = 1, bit 30 = the overflow flag and bits 29:0 = 0. It moves no pointer.
- R6: `rd_word` shows the result of a read on the cycle after `rd_en` is sampled, and holds that value until the next read.
- R7: An accepted write that brings the block count to `blk_size` resets the count to zero. It also makes `dma_req` high for one cycle, two clock edges after that write is sampled, provided no request is already waiting.
- R8: The block count advances only on accepted writes. Reads and dropped writes leave it alone. `blk_size`=0 disables requests and holds the count at zero.
- R9: `dma_req` is never high on two cycles in a row. Blocks completed while a request is pending or showing are queued, and each produces exactly one later pulse.
- R10: A read and a write in the same cycle are both honoured. If the store is not empty, `level` does not change, and this includes the full case, where no overflow occurs. If the store is empty, the read returns the empty word and the write is stored, so `level` rises by 1.
- R11: `level` gives the number of stored words. `empty` is 1 exactly when `level`=0, and `full` is 1 exactly when `level`=64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_size | input | 7 | Results per DMA request (1 to 64); 0 disables requests |
| ovf_clr | input | 1 | Control strobe that clears the overflow flag |
| wr_en | input | 1 | Write strobe for a new conversion result |
| wr_res | input | 12 | Conversion result |
| rd_en | input | 1 | Read strobe; pops one word |
| rd_word | output | 32 | Read word: result plus empty and overflow flags |
| dma_req | output | 1 | One-cycle DMA request per completed block |
| level | output | 7 | Number of stored words |
| empty | output | 1 | Store holds no data |
| full | output | 1 | Store holds 64 words |
| ovf | output | 1 | A result was dropped because the store was full |

## Verification
A wrong read or write pointer shows at the ports on the very next read. That read returns a result out of order, or returns a stale result where the empty marker was due. A `level` that drifts from the true occupancy shows within a cycle as a wrong `empty`, `full` or `ovf`. An error in the block counter or the request queue stays hidden until a block boundary, which comes at most `blk_size` accepted writes later. It then appears as a missing, early or doubled `dma_req` pulse. The bench therefore compares every port on every cycle against a reference model, under several block sizes and read/write mixes.

// File: rtl/adc_blkfifo_pkg.sv
package adc_blkfifo_pkg;
  localparam int RES_W     = 12;
  localparam int WORD_W    = 32;
  localparam int EMPTY_BIT = 31;
  localparam int OVF_BIT   = 30;

  // Build the read word: flags in the top bits, result low, zero elsewhere
  function automatic logic [WORD_W-1:0] pack_word(input logic is_empty,
                                                  input logic ovf_flag,
                                                  input logic [RES_W-1:0] res);
    logic [WORD_W-1:0] w;
    w            = '0;
    w[EMPTY_BIT] = is_empty;
    w[OVF_BIT]   = ovf_flag;
    if (!is_empty) w[RES_W-1:0] = res;
    return w;
  endfunction
endpackage

// File: rtl/adc_fifo_store.sv
module adc_fifo_store #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [LVL_W-1:0]  level,
  output logic              empty,
  output logic              full
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic [LVL_W-1:0]  level_nx;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  // Memory with registered read and no reset, so it can map to block RAM
  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
    if (pop)  dout      <= mem[rptr];
  end

  always_comb begin
    level_nx = level;
    if (push && !pop)      level_nx = level + LVL_W'(1);
    else if (pop && !push) level_nx = level - LVL_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
      empty <= 1'b1;
      full  <= 1'b0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      level <= level_nx;
      empty <= (level_nx == '0);
      full  <= (level_nx == LVL_W'(DEPTH));
    end
  end
endmodule

// File: rtl/adc_blk_req.sv
module adc_blk_req #(
  parameter int LVL_W  = 7,
  parameter int PEND_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_acc,
  input  logic [LVL_W-1:0] blk_size,
  output logic             dma_req
);
  logic [LVL_W-1:0]  cnt;
  logic [PEND_W-1:0] pend;
  logic              blk_done, issue;

  assign blk_done = wr_acc && (blk_size != '0) &&
                    (({1'b0, cnt} + (LVL_W + 1)'(1)) >= {1'b0, blk_size});
  // A request waits one cycle after each pulse so pulses stay separate
  assign issue    = (pend != '0) && !dma_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pend    <= '0;
      dma_req <= 1'b0;
    end else begin
      if (blk_size == '0)  cnt <= '0;
      else if (blk_done)   cnt <= '0;
      else if (wr_acc)     cnt <= cnt + LVL_W'(1);
      pend    <= pend + PEND_W'(blk_done) - PEND_W'(issue);
      dma_req <= issue;
    end
  end
endmodule

// File: rtl/adc_blkfifo.sv
module adc_blkfifo
  import adc_blkfifo_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int PEND_W = 12,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LVL_W-1:0]  blk_size,
  input  logic              ovf_clr,
  input  logic              wr_en,
  input  logic [RES_W-1:0]  wr_res,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_word,
  output logic              dma_req,
  output logic [LVL_W-1:0]  level,
  output logic              empty,
  output logic              full,
  output logic              ovf
);
  logic             wr_acc, rd_acc;
  logic [RES_W-1:0] rd_res;
  logic             rd_empty_q, rd_ovf_q;

  // A read in the same cycle frees a slot, so a write to a full store is taken
  assign wr_acc = wr_en && (!full || rd_en);
  assign rd_acc = rd_en && !empty;

  adc_fifo_store #(.DATA_W(RES_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .push(wr_acc), .pop(rd_acc), .din(wr_res),
    .dout(rd_res), .level(level), .empty(empty), .full(full)
  );

  adc_blk_req #(.LVL_W(LVL_W), .PEND_W(PEND_W)) u_req (
    .clk(clk), .rst(rst), .wr_acc(wr_acc), .blk_size(blk_size), .dma_req(dma_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf        <= 1'b0;
      rd_empty_q <= 1'b1;
      rd_ovf_q   <= 1'b0;
    end else begin
      if (wr_en && !wr_acc) ovf <= 1'b1;
      else if (ovf_clr)     ovf <= 1'b0;
      if (rd_en) begin
        rd_empty_q <= empty;
        rd_ovf_q   <= ovf;
      end
    end
  end

  assign rd_word = pack_word(rd_empty_q, rd_ovf_q, rd_res);
endmodule

// File: rtl/adc_blkfifo_chk.sv
module adc_blkfifo_chk #(
  parameter int LVL_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             ovf_clr,
  input logic             wr_en,
  input logic             rd_en,
  input logic [31:0]      rd_word,
  input logic             dma_req,
  input logic [LVL_W-1:0] level,
  input logic             empty,
  input logic             full,
  input logic             ovf
);
  p_valid_word_r2: assert property (@(posedge clk) disable iff (rst)
    rd_en && !empty |=> !rd_word[31] && rd_word[29:12] == '0);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    full && wr_en && !rd_en |=> ovf && full && level == $past(level));

  p_ovf_clear_r4: assert property (@(posedge clk) disable iff (rst)
    ovf_clr && !(full && wr_en && !rd_en) |=> !ovf);

  p_empty_word_r5: assert property (@(posedge clk) disable iff (rst)
    rd_en && empty |=> rd_word[31] && rd_word[29:0] == '0);

  p_req_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    dma_req |=> !dma_req);

  p_level_hold_r10: assert property (@(posedge clk) disable iff (rst)
    rd_en && wr_en && !empty |=> level == $past(level));

  p_flags_r11: assert property (@(posedge clk) disable iff (rst)
    !(empty && full) && (empty == (level == '0)));
endmodule

bind adc_blkfifo adc_blkfifo_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .ovf_clr(ovf_clr), .wr_en(wr_en), .rd_en(rd_en),
  .rd_word(rd_word), .dma_req(dma_req), .level(level), .empty(empty),
  .full(full), .ovf(ovf)
);

// File: tb/adc_blkfifo_test.sv
module adc_blkfifo_test;
  localparam int DEPTH = 64;
  localparam int LW    = 7;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1;
  logic [LW-1:0] blk_size = 7'd16;
  logic          ovf_clr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0]   wr_res = '0;
  logic [31:0]   rd_word;
  logic          dma_req, empty, full, ovf;
  logic [LW-1:0] level;

  adc_blkfifo uut (
    .clk(clk), .rst(rst), .blk_size(blk_size), .ovf_clr(ovf_clr),
    .wr_en(wr_en), .wr_res(wr_res), .rd_en(rd_en), .rd_word(rd_word),
    .dma_req(dma_req), .level(level), .empty(empty), .full(full), .ovf(ovf)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  logic [11:0] mq[$];
  int  m_cnt = 0, m_pend = 0;
  bit  m_req = 1'b0, m_ovf = 1'b0;
  int  pulses = 0;

  task automatic chk(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(bit e, bit o, logic [11:0] d);
    return e ? {1'b1, o, 30'b0} : {1'b0, o, 18'b0, d};
  endfunction

  task automatic step(bit w, bit r, bit c, logic [11:0] d);
    bit pre_empty, pre_full, acc, done, issue, o_pre;
    logic [11:0] v;
    logic [31:0] ew;
    pre_empty = (mq.size() == 0);
    pre_full  = (mq.size() == DEPTH);
    o_pre     = m_ovf;
    ew        = '0;
    if (r) begin
      if (pre_empty) ew = exp_word(1'b1, o_pre, '0);
      else begin
        v  = mq.pop_front();
        ew = exp_word(1'b0, o_pre, v);
      end
    end
    acc = w && (!pre_full || r);
    if (acc) mq.push_back(d);
    if (w && !acc) m_ovf = 1'b1;
    else if (c)    m_ovf = 1'b0;
    done = acc && (blk_size != 0) && (m_cnt + 1 >= int'(blk_size));
    if (blk_size == 0 || done) m_cnt = 0;
    else if (acc) m_cnt++;
    issue  = (m_pend > 0) && !m_req;
    m_req  = issue;
    m_pend = m_pend + int'(done) - int'(issue);

    wr_en = w; rd_en = r; ovf_clr = c; wr_res = d;
    @(posedge clk); #2;
    wr_en = 1'b0; rd_en = 1'b0; ovf_clr = 1'b0;

    chk("R11 level", level, mq.size());
    chk("R11 empty", empty, mq.size() == 0);
    chk("R11 full", full, mq.size() == DEPTH);
    chk("R3/R4 ovf", ovf, m_ovf);
    chk("R7/R9 dma_req", dma_req, m_req);
    if (dma_req) pulses++;
    if (r) chk("R2/R5/R6/R10 rd_word", rd_word, ew);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, '0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int p0;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    chk("R1 level", level, 0);
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 ovf", ovf, 0);
    chk("R1 dma_req", dma_req, 0);
    chk("R1 rd_word", rd_word, 32'h8000_0000);
    rst = 1'b0;

    // R7/R8: 20 writes with block 16, reads between do not move the count
    blk_size = 7'd16;
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 1'b0, 12'(i + 12'h100));
    for (int i = 0; i < 3; i++)  step(1'b0, 1'b1, 1'b0, '0);
    for (int i = 10; i < 20; i++) step(1'b1, 1'b0, 1'b0, 12'(i + 12'h100));
    idle(3);

    // R3/R10/R4: fill, overflow, full read+write, clear with collision
    while (mq.size() < DEPTH) step(1'b1, 1'b0, 1'b0, 12'($urandom));
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 12'hABC);
    step(1'b1, 1'b1, 1'b0, 12'h5A5);
    step(1'b1, 1'b0, 1'b1, 12'h111);
    step(1'b0, 1'b1, 1'b0, '0);
    step(1'b0, 1'b0, 1'b1, '0);

    // R5/R10: drain, read empty, read+write on empty
    while (mq.size() > 0) step(1'b0, 1'b1, 1'b0, '0);
    step(1'b0, 1'b1, 1'b0, '0);
    step(1'b0, 1'b1, 1'b0, '0);
    step(1'b1, 1'b1, 1'b0, 12'h7E1);
    step(1'b0, 1'b1, 1'b0, '0);

    // R9: block size 1, back-to-back completions queue up
    blk_size = 7'd1;
    p0 = pulses;
    for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 1'b0, 12'(i));
    idle(14);
    chk("R9 pulse count", pulses - p0, 10);

    // R8: size 0 disables requests
    blk_size = 7'd0;
    p0 = pulses;
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b0, 12'(i));
    idle(3);
    chk("R8 no request when disabled", pulses - p0, 0);

    // Random phases with different block sizes and read/write mixes
    for (int ph = 0; ph < 6; ph++) begin
      int wp, rp;
      case (ph)
        0: begin blk_size = 7'd16; wp = 70; rp = 40; end
        1: begin blk_size = 7'd64; wp = 60; rp = 55; end
        2: begin blk_size = 7'd3;  wp = 50; rp = 50; end
        3: begin blk_size = 7'd16; wp = 30; rp = 75; end
        4: begin blk_size = 7'd5;  wp = 90; rp = 20; end
        default: begin blk_size = 7'd2; wp = 45; rp = 60; end
      endcase
      for (int i = 0; i < 2500; i++)
        step(($urandom % 100) < wp, ($urandom % 100) < rp,
             ($urandom % 100) < 3, 12'($urandom));
      idle(2 * m_pend + 4);
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule